// File: doc/BRIEF.md
# Continuous Array Read Sequencer

This block is the read front end of a serial flash-style memory. A host selects the device with an active-low chip select and clocks a command in on the serial input. The command is an 8-bit read opcode, a 24-bit address and, depending on the opcode, zero, one or four dummy bytes. The block decodes that command and loads a byte address (a page number and an offset) into a counter. From then on it fetches one byte per byte time from a synchronous array read port and shifts each byte out on the serial output, MSB first, on falling SCK edges.

The four supported read opcodes share one address counter. They differ in how many dummy bytes come before the data. They also differ in what the counter does at the end of a page: it either rolls into the next page (and from page 511 back to page 0), or it returns to the start of the same page. A mode input selects between 264-byte pages and 256-byte pages, and this changes how the 24-bit address is split. Program, erase and any page buffer are outside this block, and a read never writes anything.

The serial pins are sampled in the `clk` domain. SCK must stay high for at least two `clk` cycles and low for at least two `clk` cycles. The array port returns data one `clk` after a read request.

Top module: `rdseq_array_read`

## Requirements
- R1: Opcode 0Bh takes the address and then one dummy byte. All command bits are taken on rising SCK edges, MSB first.
- R2: Opcode 03h takes the address and no dummy byte. Data follows the last address bit directly.
- R3: Opcode E8h takes the address and then four dummy bytes before data.
- R4: Opcode D2h takes the address and four dummy bytes. After the last offset of a page it continues at offset 0 of the same page.
- R5: Under 0Bh, 03h and E8h, the read moves from the last offset of a page to offset 0 of the next page with no gap. After page 511 it moves to page 0.
- R6: With `bin_mode` low, address bits 17:9 are the page and bits 8:0 are the offset, and bits 23:18 are ignored. The last offset is 263. Any offset of 263 or more is followed by offset 0.
- R7: With `bin_mode` high, address bits 16:8 are the page and bits 7:0 are the offset, and bits 23:17 are ignored. The last offset is 255.
- R8: One `clk` after `cs_n` is seen high, `so_oe` is low and no array read is issued. The next select starts again with an opcode.
- R9: Any other opcode causes no array read, and `so_oe` stays low until deselect.
- R10: The MSB of the first byte is driven on the SCK fall that follows the last address or dummy bit. A full n-byte read issues n+1 array reads, each one `clk` long, with data expected one `clk` later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; serial pins are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low select; high aborts and idles the sequencer |
| sck | input | 1 | Serial clock, sampled; rising edge takes input, falling edge drives output |
| si | input | 1 | Serial command, address and dummy input |
| bin_mode | input | 1 | 1 selects 256-byte pages, 0 selects 264-byte pages |
| so | output | 1 | Serial data output |
| so_oe | output | 1 | Output enable for `so`; low means high impedance |
| arr_rd_en | output | 1 | Array read request, one `clk` per byte |
| arr_page | output | 9 | Page number of the requested byte |
| arr_off | output | 9 | Offset within the page of the requested byte |
| arr_data | input | 8 | Array byte, valid one `clk` after `arr_rd_en` |

## Verification
The embedded properties check the counter's page-end behaviour on every cycle: the offset goes back to zero, the page is held under the page-wrap opcode, and the page advances otherwise. They also check that the output enable and read requests drop after deselect, that an ignored command stays silent, and that the output enable only rises on a falling SCK edge. Whether each opcode waits for the correct number of dummy bytes, how the address is split in each page mode, the first-bit timing and the actual byte stream can only be seen in the bench. There, a scoreboard compares every shifted-out byte with a value computed from the page and offset that the requirements predict.

// File: rtl/rdseq_pkg.sv
package rdseq_pkg;

  typedef enum logic [2:0] {
    PH_OPC,
    PH_ADDR,
    PH_DUMMY,
    PH_DATA,
    PH_IGNORE
  } phase_t;

  localparam logic [7:0] OPC_RD_FAST   = 8'h0B;
  localparam logic [7:0] OPC_RD_SLOW   = 8'h03;
  localparam logic [7:0] OPC_RD_LEGACY = 8'hE8;
  localparam logic [7:0] OPC_RD_PAGE   = 8'hD2;

endpackage

// File: rtl/rdseq_opc_decode.sv
module rdseq_opc_decode
  import rdseq_pkg::*;
#(
  parameter int DUMMY_W = 3
) (
  input  logic [7:0]         opc,
  output logic               known,
  output logic [DUMMY_W-1:0] dummy_bytes,
  output logic               page_wrap
);

  always_comb begin
    known       = 1'b1;
    dummy_bytes = '0;
    page_wrap   = 1'b0;
    case (opc)
      OPC_RD_FAST:   dummy_bytes = DUMMY_W'(1);
      OPC_RD_SLOW:   dummy_bytes = '0;
      OPC_RD_LEGACY: dummy_bytes = DUMMY_W'(4);
      OPC_RD_PAGE: begin
        dummy_bytes = DUMMY_W'(4);
        page_wrap   = 1'b1;
      end
      default:       known = 1'b0;
    endcase
  end

endmodule

// File: rtl/rdseq_addr_ctr.sv
module rdseq_addr_ctr #(
  parameter int PAGE_W    = 9,
  parameter int OFF_W     = 9,
  parameter int STD_BYTES = 264,
  parameter int BIN_BYTES = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              load_adv,
  input  logic [PAGE_W-1:0] ld_page,
  input  logic [OFF_W-1:0]  ld_off,
  input  logic              step,
  input  logic              page_wrap,
  input  logic              bin_mode,
  output logic [PAGE_W-1:0] page_q,
  output logic [OFF_W-1:0]  off_q
);

  localparam logic [OFF_W-1:0] STD_LAST = OFF_W'(STD_BYTES - 1);
  localparam logic [OFF_W-1:0] BIN_LAST = OFF_W'(BIN_BYTES - 1);

  function automatic logic [PAGE_W+OFF_W-1:0] advance(
    input logic [PAGE_W-1:0] pg,
    input logic [OFF_W-1:0]  of,
    input logic              bin,
    input logic              wrap
  );
    logic [OFF_W-1:0] lst;
    lst = bin ? BIN_LAST : STD_LAST;
    if (of >= lst) return {(wrap ? pg : pg + 1'b1), {OFF_W{1'b0}}};
    return {pg, of + 1'b1};
  endfunction

  logic [OFF_W-1:0] last_off;
  assign last_off = bin_mode ? BIN_LAST : STD_LAST;

  always_ff @(posedge clk) begin
    if (rst) begin
      page_q <= '0;
      off_q  <= '0;
    end else if (load) begin
      if (load_adv) {page_q, off_q} <= advance(ld_page, ld_off, bin_mode, page_wrap);
      else          {page_q, off_q} <= {ld_page, ld_off};
    end else if (step) begin
      {page_q, off_q} <= advance(page_q, off_q, bin_mode, page_wrap);
    end
  end

  AST_OFF_RESTART: assert property (@(posedge clk) disable iff (rst)
    (step && !load && off_q >= last_off) |=> (off_q == '0)); // R6

  AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (step && !load && page_wrap && off_q >= last_off) |=> (page_q == $past(page_q))); // R4

  AST_PAGE_NEXT: assert property (@(posedge clk) disable iff (rst)
    (step && !load && !page_wrap && off_q >= last_off)
      |=> (page_q == PAGE_W'($past(page_q) + 1'b1))); // R5

endmodule

// File: rtl/rdseq_so_shift.sv
module rdseq_so_shift #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          active,
  input  logic          sck_fall,
  input  logic          rd_pend,
  input  logic [DW-1:0] rd_data,
  output logic          so,
  output logic          so_oe,
  output logic          fetch
);

  localparam int PTR_W = $clog2(DW);

  logic [PTR_W-1:0] ptr_q;
  logic [DW-1:0]    cur_q;
  logic [DW-1:0]    nxt_q;
  logic [DW-1:0]    src;

  assign src   = rd_pend ? rd_data : nxt_q;
  assign fetch = active && sck_fall && (ptr_q == '0);

  always_ff @(posedge clk) begin
    if (rst) nxt_q <= '0;
    else if (rd_pend) nxt_q <= rd_data;
  end

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      ptr_q <= '0;
      cur_q <= '0;
      so    <= 1'b0;
      so_oe <= 1'b0;
    end else if (sck_fall) begin
      so_oe <= 1'b1;
      ptr_q <= ptr_q + 1'b1;
      if (ptr_q == '0) begin
        so    <= src[DW-1];
        cur_q <= {src[DW-2:0], 1'b0};
      end else begin
        so    <= cur_q[DW-1];
        cur_q <= {cur_q[DW-2:0], 1'b0};
      end
    end
  end

  AST_OE_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    $rose(so_oe) |-> $past(sck_fall)); // R10

endmodule

// File: rtl/rdseq_array_read.sv
module rdseq_array_read
  import rdseq_pkg::*;
#(
  parameter int PAGE_W    = 9,
  parameter int OFF_W     = 9,
  parameter int DW        = 8,
  parameter int ADDR_BITS = 24,
  parameter int STD_BYTES = 264,
  parameter int BIN_BYTES = 256,
  parameter int MAX_DUMMY = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              si,
  input  logic              bin_mode,
  output logic              so,
  output logic              so_oe,
  output logic              arr_rd_en,
  output logic [PAGE_W-1:0] arr_page,
  output logic [OFF_W-1:0]  arr_off,
  input  logic [DW-1:0]     arr_data
);

  localparam int BCNT_W  = $clog2(ADDR_BITS);
  localparam int DUMMY_W = $clog2(MAX_DUMMY + 1);
  localparam int HOLD_W  = PAGE_W + OFF_W;
  localparam int BOFF_W  = $clog2(BIN_BYTES);

  logic               sck_q;
  logic               sck_rise, sck_fall, active;
  phase_t             phase_q;
  logic [BCNT_W-1:0]  bcnt_q;
  logic [DUMMY_W-1:0] dcnt_q, dummy_q, dec_dummy;
  logic               wrap_q, dec_wrap, dec_known;
  logic [6:0]         opc_sr;
  logic [7:0]         opc_now;
  logic [HOLD_W-1:0]  addr_sr, addr_now;
  logic [PAGE_W-1:0]  ld_page, ctr_page;
  logic [OFF_W-1:0]   ld_off, ctr_off;
  logic               opc_last, addr_done, dummy_done, load_adv, fetch, step;
  logic               rd_pend;

  assign sck_rise = sck & ~sck_q;
  assign sck_fall = ~sck & sck_q;
  assign active   = ~cs_n;
  assign opc_now  = {opc_sr, si};
  assign addr_now = {addr_sr[HOLD_W-2:0], si};

  always_comb begin
    if (bin_mode) begin
      ld_page = addr_now[BOFF_W+PAGE_W-1:BOFF_W];
      ld_off  = OFF_W'(addr_now[BOFF_W-1:0]);
    end else begin
      ld_page = addr_now[OFF_W+PAGE_W-1:OFF_W];
      ld_off  = addr_now[OFF_W-1:0];
    end
  end

  assign opc_last   = active && sck_rise && phase_q == PH_OPC && bcnt_q == BCNT_W'(7);
  assign addr_done  = active && sck_rise && phase_q == PH_ADDR &&
                      bcnt_q == BCNT_W'(ADDR_BITS - 1);
  assign dummy_done = active && sck_rise && phase_q == PH_DUMMY &&
                      bcnt_q == BCNT_W'(7) && dcnt_q == DUMMY_W'(dummy_q - 1'b1);
  assign load_adv   = addr_done && dummy_q == '0;
  assign step       = dummy_done || fetch;

  rdseq_opc_decode #(.DUMMY_W(DUMMY_W)) u_dec (
    .opc         (opc_now),
    .known       (dec_known),
    .dummy_bytes (dec_dummy),
    .page_wrap   (dec_wrap)
  );

  rdseq_addr_ctr #(
    .PAGE_W(PAGE_W), .OFF_W(OFF_W), .STD_BYTES(STD_BYTES), .BIN_BYTES(BIN_BYTES)
  ) u_ctr (
    .clk       (clk),
    .rst       (rst),
    .load      (addr_done),
    .load_adv  (load_adv),
    .ld_page   (ld_page),
    .ld_off    (ld_off),
    .step      (step),
    .page_wrap (wrap_q),
    .bin_mode  (bin_mode),
    .page_q    (ctr_page),
    .off_q     (ctr_off)
  );

  rdseq_so_shift #(.DW(DW)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .active   (active && phase_q == PH_DATA),
    .sck_fall (sck_fall),
    .rd_pend  (rd_pend),
    .rd_data  (arr_data),
    .so       (so),
    .so_oe    (so_oe),
    .fetch    (fetch)
  );

  always_ff @(posedge clk) begin
    if (rst) sck_q <= 1'b0;
    else     sck_q <= sck;
  end

  always_ff @(posedge clk) begin
    if (rst || cs_n) begin
      phase_q <= PH_OPC;
      bcnt_q  <= '0;
      dcnt_q  <= '0;
      dummy_q <= '0;
      wrap_q  <= 1'b0;
      opc_sr  <= '0;
      addr_sr <= '0;
    end else if (sck_rise) begin
      case (phase_q)
        PH_OPC: begin
          opc_sr <= opc_now[6:0];
          if (opc_last) begin
            bcnt_q  <= '0;
            dummy_q <= dec_dummy;
            wrap_q  <= dec_wrap;
            phase_q <= dec_known ? PH_ADDR : PH_IGNORE;
          end else begin
            bcnt_q <= bcnt_q + 1'b1;
          end
        end
        PH_ADDR: begin
          addr_sr <= addr_now;
          if (addr_done) begin
            bcnt_q  <= '0;
            phase_q <= (dummy_q == '0) ? PH_DATA : PH_DUMMY;
          end else begin
            bcnt_q <= bcnt_q + 1'b1;
          end
        end
        PH_DUMMY: begin
          if (bcnt_q == BCNT_W'(7)) begin
            bcnt_q <= '0;
            if (dummy_done) begin
              dcnt_q  <= '0;
              phase_q <= PH_DATA;
            end else begin
              dcnt_q <= dcnt_q + 1'b1;
            end
          end else begin
            bcnt_q <= bcnt_q + 1'b1;
          end
        end
        default: phase_q <= phase_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      arr_rd_en <= 1'b0;
      arr_page  <= '0;
      arr_off   <= '0;
      rd_pend   <= 1'b0;
    end else begin
      arr_rd_en <= load_adv || dummy_done || fetch;
      rd_pend   <= arr_rd_en;
      if (load_adv) begin
        arr_page <= ld_page;
        arr_off  <= ld_off;
      end else if (dummy_done || fetch) begin
        arr_page <= ctr_page;
        arr_off  <= ctr_off;
      end
    end
  end

  AST_SO_RELEASE: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> !so_oe); // R8

  AST_NO_READ_IDLE: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> !arr_rd_en); // R8

  AST_IGNORE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_IGNORE) |-> (!so_oe && !arr_rd_en)); // R9

  AST_DATA_AFTER_HDR: assert property (@(posedge clk) disable iff (rst)
    (arr_rd_en && !$past(fetch)) |-> $past(addr_done || dummy_done)); // R10

endmodule

// File: tb/rdseq_array_read_bench.sv
module rdseq_array_read_bench;

  localparam int CLK_PERIOD = 10;
  localparam int HALF_SCK   = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1;
  logic       sck = 1'b0;
  logic       si = 1'b0;
  logic       bin_mode = 1'b0;
  logic       so, so_oe, arr_rd_en;
  logic [8:0] arr_page, arr_off;
  logic [7:0] arr_data = 8'h00;

  int total = 0;
  int bad = 0;
  int rd_cnt = 0;
  bit oe_seen = 1'b0;
  bit mon_on = 1'b0;
  bit done = 1'b0;
  string cur_tag = "R1";
  logic [7:0] exp_q[$];
  logic [7:0] mon_sr = 8'h00;
  int mon_bits = 0;
  bit mon_oe_bad = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rdseq_array_read u_rdseq_array_read (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si), .bin_mode(bin_mode),
    .so(so), .so_oe(so_oe), .arr_rd_en(arr_rd_en), .arr_page(arr_page),
    .arr_off(arr_off), .arr_data(arr_data)
  );

  function automatic logic [7:0] mem_val(input logic [8:0] p, input logic [8:0] o);
    logic [15:0] t;
    t = 16'(p) * 16'd37 + 16'(o) * 16'd11;
    return t[7:0] ^ {o[8], 6'b0, p[8]};
  endfunction

  // synchronous array model: data one clk after the request
  always @(posedge clk) begin
    if (arr_rd_en) arr_data <= mem_val(arr_page, arr_off);
    if (arr_rd_en) rd_cnt = rd_cnt + 1;
    if (so_oe) oe_seen = 1'b1;
  end

  task automatic check(input string tag, input int act, input int exp, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // monitor: host samples SO on rising SCK, compares each byte with the queue
  always @(posedge sck) begin
    if (mon_on) begin
      if (!so_oe) mon_oe_bad = 1'b1;
      mon_sr = {mon_sr[6:0], so};
      mon_bits++;
      if (mon_bits == 8) begin
        mon_bits = 0;
        total++;
        if (exp_q.size() == 0) begin
          bad++;
          $display("FAIL %s extra byte: actual=%0h expected=none", cur_tag, mon_sr);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          if (mon_sr !== e || mon_oe_bad) begin
            bad++;
            $display("FAIL %s data byte: actual=%0h oe_ok=%0d expected=%0h",
                     cur_tag, mon_sr, !mon_oe_bad, e);
          end
        end
        mon_oe_bad = 1'b0;
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sbit(input logic b);
    si  = b;
    sck = 1'b0;
    tick(HALF_SCK);
    sck = 1'b1;
    tick(HALF_SCK);
  endtask

  // driver: issues one read, pushes the expected bytes, drives all SCK edges
  task automatic run_cmd(input string tag, input logic [7:0] opc, input logic bin,
                         input logic mode3, input logic [8:0] pg, input logic [8:0] of,
                         input int nbytes, input int dummies, input logic wrap,
                         input int extra_bits);
    logic [23:0] aw;
    logic [8:0]  p, o, lst;
    cur_tag  = tag;
    bin_mode = bin;
    sck      = mode3;
    tick(2);
    p = pg; o = of; lst = bin ? 9'd255 : 9'd263;
    for (int i = 0; i < nbytes; i++) begin
      exp_q.push_back(mem_val(p, o));
      if (o >= lst) begin
        o = 9'd0;
        if (!wrap) p = p + 9'd1;
      end else begin
        o = o + 9'd1;
      end
    end
    aw = bin ? {7'b0, pg, of[7:0]} : {6'b0, pg, of};
    cs_n = 1'b0;
    tick(1);
    rd_cnt = 0;
    for (int i = 7; i >= 0; i--) sbit(opc[i]);
    for (int i = 23; i >= 0; i--) sbit(aw[i]);
    for (int i = 0; i < dummies * 8; i++) sbit(1'b0);
    mon_bits = 0;
    mon_on   = 1'b1;
    for (int i = 0; i < nbytes * 8; i++) sbit(1'b1);
    mon_on = 1'b0;
    for (int i = 0; i < extra_bits; i++) sbit(1'b0);
    tick(1);
    if (extra_bits == 0) check("R10", rd_cnt, nbytes + 1, "array read count");
    cs_n = 1'b1;
    tick(2);
    check("R8", so_oe, 0, "so_oe after deselect");
    check(tag, exp_q.size(), 0, "bytes left unread");
    exp_q.delete();
    sck = 1'b0;
    tick(2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R10 watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(4);
    rst = 1'b0;
    tick(2);
    check("R8", so_oe, 0, "so_oe after reset");
    check("R8", arr_rd_en, 0, "rd_en after reset");

    // R1 one dummy byte, 264-byte pages (R6 field split)
    run_cmd("R1", 8'h0B, 1'b0, 1'b0, 9'd5, 9'd10, 6, 1, 1'b0, 0);
    // R2 no dummy, 256-byte pages (R7 field split)
    run_cmd("R2", 8'h03, 1'b1, 1'b0, 9'd7, 9'd3, 5, 0, 1'b0, 0);
    // R3 four dummy bytes, crosses page 2 -> 3 at offset 263 (R5, R6)
    run_cmd("R3", 8'hE8, 1'b0, 1'b0, 9'd2, 9'd260, 8, 4, 1'b0, 0);
    // R4 page read stays in page 9, 256-byte mode (R7)
    run_cmd("R4", 8'hD2, 1'b1, 1'b0, 9'd9, 9'd253, 6, 4, 1'b1, 0);
    // R4 page read stays in page 1, 264-byte mode, host in SCK-idle-high mode
    run_cmd("R4", 8'hD2, 1'b0, 1'b1, 9'd1, 9'd262, 4, 4, 1'b1, 0);
    // R5 array end rolls to page 0, 256-byte mode
    run_cmd("R5", 8'h0B, 1'b1, 1'b0, 9'd511, 9'd254, 5, 1, 1'b0, 0);
    // R5 array end rolls to page 0, 264-byte mode, SCK idle high
    run_cmd("R5", 8'h03, 1'b0, 1'b1, 9'd511, 9'd262, 4, 0, 1'b0, 0);
    // R6 offset beyond the page end is followed by offset 0 of the next page
    run_cmd("R6", 8'h03, 1'b0, 1'b0, 9'd10, 9'd300, 3, 0, 1'b0, 0);
    // R7 256-byte mode, crossing into the next page
    run_cmd("R7", 8'hE8, 1'b1, 1'b0, 9'd300, 9'd254, 4, 4, 1'b0, 0);
    // R8 abort part way through a byte, then a fresh command
    run_cmd("R8", 8'h0B, 1'b0, 1'b0, 9'd4, 9'd0, 2, 1, 1'b0, 3);
    run_cmd("R8", 8'h03, 1'b1, 1'b0, 9'd6, 9'd100, 3, 0, 1'b0, 0);

    // R9 unknown opcode: no read and SO left undriven
    cur_tag  = "R9";
    bin_mode = 1'b0;
    cs_n = 1'b0;
    tick(1);
    rd_cnt  = 0;
    oe_seen = 1'b0;
    for (int i = 7; i >= 0; i--) sbit(i[0]);
    for (int i = 0; i < 64; i++) sbit(1'b1);
    tick(2);
    check("R9", rd_cnt, 0, "array reads on unknown opcode");
    check("R9", oe_seen, 0, "so_oe on unknown opcode");
    cs_n = 1'b1;
    sck  = 1'b0;
    tick(3);
    // R1 read after the ignored command still works
    run_cmd("R1", 8'h0B, 1'b1, 1'b0, 9'd20, 9'd0, 3, 1, 1'b0, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule